// File: doc/BRIEF.md
# Configurable Read Output Pipeline

This block sits between the storage array of a synchronous memory and its bidirectional data pins. It owns the read-data path and the logic that decides when the pins are driven. Each clock it takes one command: idle, read, write or deselect. For a read, the array returns a word during the cycle after the command is captured.

A latency mode input picks one of two read paths. In one, the word passes straight through to the pins, giving a 2-1-1-1 burst. In the other, it goes through a rising-edge output register, giving a 3-1-1-1 burst. A second mode input picks how fast the pins are released after a deselect or write. In dual-cycle deselect, the release command is delayed by as many stages as a read. In single-cycle deselect, it is delayed by one stage fewer.

Once a read has reached the output stage, the pins stay driven through idle commands until a release takes effect. An active-low output enable gates the drivers without involving the clock.

Top module: `read_out_pipe`

## Requirements
- R1: During and right after synchronous reset, `dq_oe` is low. With `pipe_en` high, `dq_o` reads all zeros because the output register is cleared.
- R2: With `pipe_en` high, a read captured at rising edge k is driven from edge k+1 onward. The value is the `arr_data` word presented between edges k and k+1. The first sample point is edge k+2 (3-1-1-1).
- R3: With `pipe_en` low, a read captured at edge k is driven from edge k onward. `dq_o` follows `arr_data` combinationally, including changes in the middle of a cycle (2-1-1-1).
- R4: Consecutive read commands with `pipe_en` high put one new word per clock on `dq_o`, in command order.
- R5: With `pipe_en` high and `dual_desel` high, a deselect (`cmd`=2'b11) captured at edge k leaves the pins driven until edge k+1. It releases them at edge k+1.
- R6: With `pipe_en` high and `dual_desel` low, a deselect captured at edge k releases the pins at edge k.
- R7: With `pipe_en` low, a deselect captured at edge k releases the pins at edge k, whatever the value of `dual_desel`.
- R8: A write (`cmd`=2'b10) releases the pins with exactly the timing of a deselect in every mode.
- R9: Idle commands (`cmd`=2'b00) leave the drive state unchanged. With `pipe_en` high, they also leave `dq_o` unchanged.
- R10: While `oe_n` is high, `dq_oe` is low at once, without waiting for a clock edge. Lowering `oe_n` again restores the drive and data the pipeline had kept.
- R11: If a release and a read reach their decision points at the same edge, the release wins and the pins stay off. This is the case of a read followed directly by a deselect in pipelined single-cycle mode.
- R12: `dq` carries `dq_o` whenever `dq_oe` is high. Drive and data follow R2 to R11 under any mix of commands and mode changes. A read command is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_en | input | 1 | 1 = registered read path, 0 = flow-through |
| dual_desel | input | 1 | 1 = dual-cycle deselect, 0 (tie-off) = single-cycle |
| cmd | input | 2 | 00 idle, 01 read, 10 write, 11 deselect |
| arr_data | input | DW | Read word from the array, valid the cycle after the read is captured |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_o | output | DW | Data value presented to the pad drivers |
| dq_oe | output | 1 | Pad driver enable |
| dq | output | DW | Tri-state data bus |

## Verification
Single reads followed by idles show the release latency apart from the read latency in each of the four mode pairs. Deselect and write are each tried as the release, so a fault on only one command path shows. Back-to-back read bursts show that pipelined words are neither dropped nor repeated. A read followed directly by a deselect exposes the priority between the two. Toggling `oe_n` in the middle of a cycle, and changing `arr_data` in the middle of a cycle in flow-through mode, separate combinational paths from registered ones. Long random command streams with occasional mode flips check all of this together against a bench model.

// File: rtl/rop_pkg.sv
// Shared command type and helpers for the read output pipeline.
// Assumes one command per clock, encoded as in the port description.
package rop_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_DESEL = 2'b11
    } rop_cmd_e;

    // True for the commands that release the data pins.
    function automatic logic cmd_releases(rop_cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_DESEL);
    endfunction

endpackage

// File: rtl/rop_cmd_stage.sv
// Command capture stage: registers the incoming command once and decodes
// read/release flags both for the incoming command and for the captured one.
// Assumes the command is stable around the rising edge.
module rop_cmd_stage
    import rop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rop_cmd_e cmd_in,
    output logic     in_rd,
    output logic     in_off,
    output logic     s1_rd,
    output logic     s1_off
);

    rop_cmd_e s1_q;

    // Capture the command into the first pipeline stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= CMD_IDLE;
        end else begin
            s1_q <= cmd_in;
        end
    end

    // Decode flags for the incoming and the captured command.
    always_comb begin
        in_rd  = (cmd_in == CMD_READ);
        in_off = cmd_releases(cmd_in);
        s1_rd  = (s1_q == CMD_READ);
        s1_off = cmd_releases(s1_q);
    end

endmodule

// File: rtl/rop_en_ctl.sv
// Drive-state control: keeps a sticky flag that says the pins should be
// driven. The stage feeding the read and release decisions is chosen from
// the latency and deselect modes. Release wins over read when both arrive
// together. Assumes the mode inputs are quasi-static.
module rop_en_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic pipe_en,
    input  logic dual_desel,
    input  logic in_rd,
    input  logic in_off,
    input  logic s1_rd,
    input  logic s1_off,
    output logic en_q
);

    logic rd_evt;
    logic off_evt;

    // Pick the stage that each event is taken from, per mode.
    always_comb begin
        if (pipe_en) begin
            rd_evt  = s1_rd;
            off_evt = dual_desel ? s1_off : in_off;
        end else begin
            rd_evt  = in_rd;
            off_evt = in_off;
        end
    end

    // Update the sticky drive flag; release has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (off_evt) begin
            en_q <= 1'b0;
        end else if (rd_evt) begin
            en_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rop_data_path.sv
// Read data path: an output register loaded with the array word when the
// captured command is a read, and a mode mux that either bypasses it or
// uses it. The register is split into lanes by generate so that wide words
// map onto narrow lane flops. Assumes DW is a multiple of LANE_W.
module rop_data_path #(
    parameter int DW     = 72,
    parameter int LANE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_en,
    input  logic          s1_rd,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_o
);

    localparam int LANES = DW / LANE_W;

    logic [DW-1:0] out_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Load one lane of the output register on a captured read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q[g*LANE_W +: LANE_W] <= '0;
            end else if (s1_rd) begin
                out_q[g*LANE_W +: LANE_W] <= arr_data[g*LANE_W +: LANE_W];
            end
        end
    end

    // Select registered or flow-through data.
    always_comb begin
        dq_o = pipe_en ? out_q : arr_data;
    end

endmodule

// File: rtl/read_out_pipe.sv
// Top of the read output pipeline. Connects command capture, drive control
// and data path, then gates the drivers with the asynchronous output enable
// and builds the tri-state bus. Assumes the caller issues at most one
// command per clock and holds the mode inputs steady while the pins are in use.
module read_out_pipe #(
    parameter int DW     = 72,
    parameter int LANE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_en,
    input  logic          dual_desel,
    input  logic [1:0]    cmd,
    input  logic [DW-1:0] arr_data,
    input  logic          oe_n,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output tri   [DW-1:0] dq
);

    import rop_pkg::*;

    rop_cmd_e cmd_e;
    logic     in_rd;
    logic     in_off;
    logic     s1_rd;
    logic     s1_off;
    logic     en_q;

    assign cmd_e = rop_cmd_e'(cmd);

    rop_cmd_stage u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_in (cmd_e),
        .in_rd  (in_rd),
        .in_off (in_off),
        .s1_rd  (s1_rd),
        .s1_off (s1_off)
    );

    rop_en_ctl u_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_en    (pipe_en),
        .dual_desel (dual_desel),
        .in_rd      (in_rd),
        .in_off     (in_off),
        .s1_rd      (s1_rd),
        .s1_off     (s1_off),
        .en_q       (en_q)
    );

    rop_data_path #(
        .DW     (DW),
        .LANE_W (LANE_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe_en  (pipe_en),
        .s1_rd    (s1_rd),
        .arr_data (arr_data),
        .dq_o     (dq_o)
    );

    // Gate the driver enable with the output enable, without a clock.
    always_comb begin
        dq_oe = en_q & ~oe_n;
    end

    assign dq = dq_oe ? dq_o : {DW{1'bz}};

endmodule

// File: rtl/rop_checker.sv
// Property checker for read_out_pipe, attached by bind. Observes only the
// top-level ports. A small age counter keeps $past looks inside the
// cycles since reset.
module rop_checker #(
    parameter int DW = 72
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_en,
    input logic          dual_desel,
    input logic [1:0]    cmd,
    input logic          oe_n,
    input logic          dq_oe,
    input logic [DW-1:0] dq_o
);

    logic [1:0] age;

    // Count edges since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> !dq_oe);

    p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && pipe_en && $past(cmd) == 2'b01 && (dual_desel || !cmd[1]))
        |=> (dq_oe || oe_n));

    p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && cmd == 2'b01) |=> (dq_oe || oe_n));

    p_dcd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && pipe_en && dual_desel && $past(cmd[1])) |=> !dq_oe);

    p_scd_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_en && !dual_desel && cmd[1]) |=> !dq_oe);

    p_flow_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_en && cmd[1]) |=> !dq_oe);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && pipe_en && $past(cmd) != 2'b01) |=> (!pipe_en || $stable(dq_o)));

    // Output enable gates the drivers at once (R10).
    always_comb begin
        if (oe_n) begin
            p_oe_gate_r10: assert (!dq_oe);
        end
    end

endmodule

bind read_out_pipe rop_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_en    (pipe_en),
    .dual_desel (dual_desel),
    .cmd        (cmd),
    .oe_n       (oe_n),
    .dq_oe      (dq_oe),
    .dq_o       (dq_o)
);

// File: tb/read_out_pipe_tb.sv
module read_out_pipe_tb;

    localparam int DW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_en = 1'b1;
    logic          dual_desel = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [DW-1:0] arr_data = '0;
    logic          oe_n = 1'b0;
    wire  [DW-1:0] dq_o;
    wire           dq_oe;
    wire  [DW-1:0] dq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench model state
    logic [1:0]    m_s1 = 2'b00;
    logic          m_en = 1'b0;
    logic [DW-1:0] m_reg = '0;

    read_out_pipe #(.DW(DW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_en    (pipe_en),
        .dual_desel (dual_desel),
        .cmd        (cmd),
        .arr_data   (arr_data),
        .oe_n       (oe_n),
        .dq_o       (dq_o),
        .dq_oe      (dq_oe),
        .dq         (dq)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rnd_word();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_word(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update at a rising edge, from the requirements.
    task automatic model_edge();
        logic rdn;
        logic offn;
        if (!rst_n) begin
            m_s1 = 2'b00; m_en = 1'b0; m_reg = '0;
        end else begin
            if (pipe_en) begin
                rdn  = (m_s1 == 2'b01);
                offn = dual_desel ? m_s1[1] : cmd[1];
            end else begin
                rdn  = (cmd == 2'b01);
                offn = cmd[1];
            end
            if (offn) m_en = 1'b0;
            else if (rdn) m_en = 1'b1;
            if (m_s1 == 2'b01) m_reg = arr_data;
            m_s1 = cmd;
        end
    endtask

    // One clock: apply cmd at negedge, present array word after the edge.
    task automatic cycle(input logic [1:0] c);
        cmd = c;
        @(posedge clk);
        model_edge();
        #1 arr_data = rnd_word();
        @(negedge clk);
    endtask

    task automatic check_model(input string tag);
        logic exp_oe;
        exp_oe = m_en && !oe_n;
        chk_bit(tag, dq_oe, exp_oe);
        if (exp_oe) begin
            chk_word(tag, dq_o, pipe_en ? m_reg : arr_data);
            chk_word(tag, dq, dq_o);
        end
    endtask

    task automatic reset_all(input logic pe, input logic dd);
        rst_n = 1'b0;
        cmd = 2'b00;
        oe_n = 1'b0;
        pipe_en = pe;
        dual_desel = dd;
        cycle(2'b00);
        cycle(2'b00);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w;
        logic [DW-1:0] prev;
        @(negedge clk);
        reset_all(1'b1, 1'b0);
        // R1: reset state
        chk_bit("R1 oe after reset", dq_oe, 1'b0);
        chk_word("R1 reg cleared", dq_o, '0);
        cycle(2'b00);
        chk_bit("R1 idle after reset", dq_oe, 1'b0);

        // R2 / R9 / R6: pipelined, single-cycle deselect
        cycle(2'b01);
        chk_bit("R2 not before k+1", dq_oe, 1'b0);
        w = arr_data;
        cycle(2'b00);
        chk_bit("R2 driven after k+1", dq_oe, 1'b1);
        chk_word("R2 data", dq_o, w);
        cycle(2'b00);
        chk_bit("R9 idle holds drive", dq_oe, 1'b1);
        chk_word("R9 idle holds data", dq_o, w);
        cycle(2'b11);
        chk_bit("R6 scd release at k", dq_oe, 1'b0);

        // R5: pipelined, dual-cycle deselect
        reset_all(1'b1, 1'b1);
        cycle(2'b01);
        cycle(2'b00);
        cycle(2'b11);
        chk_bit("R5 dcd still driven", dq_oe, 1'b1);
        cycle(2'b00);
        chk_bit("R5 dcd release at k+1", dq_oe, 1'b0);

        // R8: write behaves as deselect (dual and single)
        cycle(2'b01);
        cycle(2'b00);
        cycle(2'b10);
        chk_bit("R8 dcd write still driven", dq_oe, 1'b1);
        cycle(2'b00);
        chk_bit("R8 dcd write release", dq_oe, 1'b0);
        reset_all(1'b1, 1'b0);
        cycle(2'b01);
        cycle(2'b00);
        cycle(2'b10);
        chk_bit("R8 scd write release", dq_oe, 1'b0);

        // R11: read then deselect in pipelined single-cycle mode
        reset_all(1'b1, 1'b0);
        cycle(2'b01);
        cycle(2'b11);
        chk_bit("R11 release wins", dq_oe, 1'b0);
        cycle(2'b00);
        chk_bit("R11 stays off", dq_oe, 1'b0);

        // R4: back-to-back reads
        reset_all(1'b1, 1'b1);
        cycle(2'b01);
        prev = arr_data;
        for (int i = 0; i < 4; i++) begin
            cycle(2'b01);
            chk_word("R4 burst word", dq_o, prev);
            chk_bit("R4 burst drive", dq_oe, 1'b1);
            prev = arr_data;
        end
        cycle(2'b00);
        chk_word("R4 last word", dq_o, prev);

        // R10: asynchronous output enable
        #1 oe_n = 1'b1;
        #1 chk_bit("R10 oe_n off at once", dq_oe, 1'b0);
        #1 oe_n = 1'b0;
        #1 chk_bit("R10 drive restored", dq_oe, 1'b1);
        chk_word("R10 data kept", dq_o, prev);
        @(negedge clk);

        // R3 / R7: flow-through
        reset_all(1'b0, 1'b1);
        cycle(2'b01);
        chk_bit("R3 flow driven at k", dq_oe, 1'b1);
        chk_word("R3 flow data", dq_o, arr_data);
        #1 arr_data = rnd_word();
        #1 chk_word("R3 flow follows array", dq_o, arr_data);
        @(negedge clk);
        cycle(2'b11);
        chk_bit("R7 flow release at k", dq_oe, 1'b0);
        dual_desel = 1'b0;
        cycle(2'b01);
        cycle(2'b10);
        chk_bit("R7 R8 flow write release", dq_oe, 1'b0);

        // R12: random stream against the model
        reset_all(1'b1, 1'b0);
        void'($urandom(32'd12345));
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [1:0] c;
            if (n % 60 == 59) begin
                pipe_en = $urandom_range(0, 1);
                dual_desel = $urandom_range(0, 1);
            end
            oe_n = ($urandom_range(0, 9) == 0);
            r = $urandom_range(0, 9);
            c = (r < 5) ? 2'b01 : (r < 7) ? 2'b00 : (r < 9) ? 2'b11 : 2'b10;
            cycle(c);
            check_model("R12 model");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule